// File: doc/BRIEF.md
# Reloadable Periodic Down-Counting Timer

The block is a periodic timer that counts down once for every cycle in which its tick-enable input is high. The tick input stands for one period of a 38.4 MHz reference, so the timer period is the programmed reload value times that reference period. When the count runs out, the block sets a sticky interrupt flag. In the same cycle it loads the reload value again and keeps running without any help from software. The interrupt request output is high whenever the flag is set and interrupts are enabled. An external router, outside this block, sends the request to one core.

Software controls the block through a 32-bit register port that has two registers. The control/status register holds a 28-bit reload value, a run enable, an interrupt enable and the read-only flag. The write-only acknowledge register has two independent action bits. One clears the flag. The other restarts the current period from the reload value.

A two-state machine sits at the centre of the design. `ST_IDLE` means the timer is stopped and `ST_COUNT` means it is counting. Transition START (`ST_IDLE`/`ST_COUNT` to `ST_COUNT`) happens on a control write with the enable set and a nonzero reload value, and it loads the counter. Transition STOP (any state to `ST_IDLE`) happens on a control write with the enable clear or a zero reload value. Inside `ST_COUNT` there are three self-loops. TICK decrements the counter. EXPIRE sets the flag and reloads the counter. REARM is an acknowledge reload.

Top module: `periodic_reload_timer`

## Requirements
- R1: After reset the control register reads 0x0000_0000, the interrupt request is low and the timer is stopped.
- R2: The control register layout is reload value in bits 27:0, enable in bit 28, interrupt enable in bit 29, bit 30 always reads 0, and the flag reads in bit 31. Control writes never change the flag.
- R3: While running, a reload value of N makes the flag set on the N-th tick cycle after the count was started. On that expiry the counter restarts from the reload value, so the flag sets again after every N further ticks.
- R4: The interrupt request equals interrupt enable AND flag.
- R5: A control write with the enable at 1 and a nonzero reload value restarts the count from the newly written reload value. A control write with the enable at 0 stops counting and leaves the flag as it was.
- R6: Writing the acknowledge register with bit 31 at 1 clears the flag.
- R7: Writing the acknowledge register with bit 30 at 1 restarts the current period from the reload value, but only while the timer is running.
- R8: The acknowledge register reads as zero. Any address other than the control register also reads as zero.
- R9: A reload value of zero leaves the timer stopped, even with the enable bit set, so the flag never sets.
- R10: If an expiry and a flag-clearing acknowledge fall in the same cycle, the flag ends up set.
- R11: Cycles with the tick input low do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One reference-clock period has elapsed |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Interrupt request to the router |

## Verification
Assertions check every cycle that:
- an expiry always leaves the flag set, even when a clear arrives in the same cycle;
- a clear with no expiry always leaves the flag low;
- the counter reloads on expiry;
- the counter holds when no tick arrives;
- a running timer never holds a zero count;
- stop writes and zero-reload writes always end in `ST_IDLE`.

The exact length of a period after a start, a restart or an acknowledge reload can only be shown by the bench, which counts tick cycles up to the request. The same holds for the read-back layout of the register port and for the mix of writes and ticks in random traffic, which the bench compares against its own model.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int DATA_W    = 32;
    localparam int RELOAD_W  = 28;
    localparam int EN_BIT    = 28;
    localparam int IE_BIT    = 29;
    localparam int REARM_BIT = 30;
    localparam int FLAG_BIT  = 31;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic                en;
        logic                ie;
    } tmr_cfg_t;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CTRL_OFFS = 'h34,
    parameter int ACK_OFFS  = 'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              flag,
    output tmr_cfg_t          cfg,
    output tmr_cfg_t          wr_cfg,
    output logic              ctrl_wr,
    output logic              ack_clr,
    output logic              ack_rearm,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFS);
    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_OFFS);

    logic ack_wr;

    // write decode
    always_comb begin
        ctrl_wr       = bus_wr && (bus_addr == CTRL_A);
        ack_wr        = bus_wr && (bus_addr == ACK_A);
        ack_clr       = ack_wr && bus_wdata[FLAG_BIT];
        ack_rearm     = ack_wr && bus_wdata[REARM_BIT];
        wr_cfg.reload = bus_wdata[RELOAD_W-1:0];
        wr_cfg.en     = bus_wdata[EN_BIT];
        wr_cfg.ie     = bus_wdata[IE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (ctrl_wr) begin
            cfg <= wr_cfg;
        end
    end

    // read mux: only the control register returns data
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_A) begin
            bus_rdata[RELOAD_W-1:0] = cfg.reload;
            bus_rdata[EN_BIT]       = cfg.en;
            bus_rdata[IE_BIT]       = cfg.ie;
            bus_rdata[FLAG_BIT]     = flag;
        end
    end

    // R2: configuration changes only through a control write
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(cfg));
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                ctrl_wr,
    input  logic [RELOAD_W-1:0] wr_reload,
    input  logic                wr_en,
    input  logic [RELOAD_W-1:0] cur_reload,
    input  logic                ack_rearm,
    output logic                expire,
    output tmr_state_e          state
);
    localparam logic [RELOAD_W-1:0] ONE = RELOAD_W'(1);

    tmr_state_e          state_nxt;
    logic [RELOAD_W-1:0] cnt;
    logic                start_ok;

    // next-state logic
    always_comb begin
        start_ok  = wr_en && (wr_reload != '0);
        state_nxt = state;
        if (ctrl_wr) begin
            state_nxt = start_ok ? ST_COUNT : ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // outputs
    always_comb begin
        expire = 1'b0;
        unique case (state)
            ST_IDLE:  expire = 1'b0;
            ST_COUNT: expire = tick_en && (cnt == ONE);
            default:  expire = 1'b0;
        endcase
    end

    // counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ctrl_wr) begin
            cnt <= wr_reload;
        end else if (state == ST_COUNT) begin
            if (ack_rearm || expire) cnt <= cur_reload;
            else if (tick_en)        cnt <= cnt - ONE;
        end
    end

    // R3: expiry reloads the period
    a_r3_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl_wr) |=> (cnt == $past(cur_reload)));
    // R11: no tick, no count change
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !tick_en && !ctrl_wr && !ack_rearm) |=> $stable(cnt));
    // R5: stop write idles the timer
    a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_en) |=> (state == ST_IDLE));
    // R9: zero reload never runs
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_reload == '0) |=> (state == ST_IDLE));
    a_r9_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (cnt != '0));
endmodule

// File: rtl/ptmr_flag.sv
module ptmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack_clr,
    input  logic ie,
    output logic flag,
    output logic irq_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (expire)  flag <= 1'b1;
        else if (ack_clr) flag <= 1'b0;
    end

    assign irq_req = flag && ie;

    // R10: expiry wins over a clear
    a_r10_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
    // R6: clear without expiry lowers flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !expire) |=> !flag);
    // R4: flag can only rise on expiry
    a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(expire));
endmodule

// File: rtl/periodic_reload_timer.sv
module periodic_reload_timer
    import ptmr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CTRL_OFFS = 'h34,
    parameter int ACK_OFFS  = 'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_req
);
    tmr_cfg_t   cfg;
    tmr_cfg_t   wr_cfg;
    logic       ctrl_wr;
    logic       ack_clr;
    logic       ack_rearm;
    logic       expire;
    logic       flag;
    tmr_state_e state;

    ptmr_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFFS(CTRL_OFFS),
        .ACK_OFFS (ACK_OFFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .flag     (flag),
        .cfg      (cfg),
        .wr_cfg   (wr_cfg),
        .ctrl_wr  (ctrl_wr),
        .ack_clr  (ack_clr),
        .ack_rearm(ack_rearm),
        .bus_rdata(bus_rdata)
    );

    ptmr_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .ctrl_wr   (ctrl_wr),
        .wr_reload (wr_cfg.reload),
        .wr_en     (wr_cfg.en),
        .cur_reload(cfg.reload),
        .ack_rearm (ack_rearm),
        .expire    (expire),
        .state     (state)
    );

    ptmr_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .ack_clr(ack_clr),
        .ie     (cfg.ie),
        .flag   (flag),
        .irq_req(irq_req)
    );

    // R9: running implies a live configuration
    a_r9_run_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (cfg.en && cfg.reload != '0));
    // R4: request needs interrupt enable
    a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> cfg.ie);
endmodule

// File: tb/test_periodic_reload_timer.sv
`timescale 1ns/1ps
module test_periodic_reload_timer;
    localparam int ADDR_W = 8;
    localparam logic [7:0] A_CTRL = 8'h34;
    localparam logic [7:0] A_ACK  = 8'h38;
    localparam logic [7:0] A_OTH  = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [27:0] m_reload, m_cnt;
    logic        m_en, m_ie, m_flag, m_run;

    always #2.5 clk = ~clk;

    periodic_reload_timer #(.ADDR_W(ADDR_W)) i_periodic_reload_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    function automatic logic [31:0] exp_rdata(input logic [7:0] a);
        if (a == A_CTRL) return {m_flag, 1'b0, m_ie, m_en, m_reload};
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_reload = '0; m_cnt = '0; m_en = 0; m_ie = 0; m_flag = 0; m_run = 0;
    endtask

    task automatic model_step(input logic wr, input logic [7:0] a,
                              input logic [31:0] wd, input logic tk);
        logic ex;
        ex = m_run && tk && (m_cnt == 28'd1);
        if (ex) m_flag = 1;
        else if (wr && a == A_ACK && wd[31]) m_flag = 0;
        if (wr && a == A_CTRL) begin
            m_reload = wd[27:0]; m_en = wd[28]; m_ie = wd[29];
            m_run = m_en && (m_reload != 0);
            m_cnt = m_reload;
        end else if (m_run) begin
            if ((wr && a == A_ACK && wd[30]) || ex) m_cnt = m_reload;
            else if (tk) m_cnt = m_cnt - 28'd1;
        end
    endtask

    task automatic do_cycle(input logic wr, input logic [7:0] a,
                            input logic [31:0] wd, input logic tk, input string tag);
        bus_wr = wr; bus_addr = a; bus_wdata = wd; tick_en = tk;
        @(posedge clk);
        model_step(wr, a, wd, tk);
        @(negedge clk);
        chk({tag, " irq"}, {31'b0, irq_req}, {31'b0, m_flag && m_ie});
        chk({tag, " rdata"}, bus_rdata, exp_rdata(a));
    endtask

    task automatic idle(input string tag);
        do_cycle(0, A_CTRL, 0, 0, tag);
    endtask

    task automatic ticks_to_irq(input string tag, output int n);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            do_cycle(0, A_CTRL, 0, 1, tag);
            n++;
            if (irq_req) break;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] wd;
        logic [7:0]  a;
        logic        wr;
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", bus_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq_req}, 32'h0);
        do_cycle(0, A_CTRL, 0, 1, "R1 stopped");

        // R2 layout; bits 31/30 of a control write ignored
        do_cycle(1, A_CTRL, 32'hC000_0005 | 32'h2000_0000, 0, "R2 write");
        chk("R2 readback", bus_rdata, 32'h2000_0005);

        // R3 period of 3 ticks
        do_cycle(1, A_CTRL, 32'h3000_0003, 0, "R3 start");
        ticks_to_irq("R3 first", n);
        chk("R3 first period", n, 3);
        // R6 clear, R8 ack reads zero
        do_cycle(1, A_ACK, 32'h8000_0000, 0, "R6 clear");
        chk("R6 irq low", {31'b0, irq_req}, 32'h0);
        chk("R8 ack read", bus_rdata, 32'h0);
        do_cycle(0, A_OTH, 0, 0, "R8 other");
        chk("R8 other read", bus_rdata, 32'h0);
        ticks_to_irq("R3 periodic", n);
        chk("R3 second period", n, 3);

        // R10 expiry and clear in the same cycle
        do_cycle(1, A_ACK, 32'h8000_0000, 0, "R10 pre");
        do_cycle(0, A_CTRL, 0, 1, "R10 t1");
        do_cycle(0, A_CTRL, 0, 1, "R10 t2");
        do_cycle(1, A_ACK, 32'h8000_0000, 1, "R10 collide");
        chk("R10 flag kept", {31'b0, irq_req}, 32'h1);

        // R7 rearm while running
        do_cycle(1, A_ACK, 32'h8000_0000, 0, "R7 clr");
        do_cycle(0, A_CTRL, 0, 1, "R7 t1");
        do_cycle(0, A_CTRL, 0, 1, "R7 t2");
        do_cycle(1, A_ACK, 32'h4000_0000, 0, "R7 rearm");
        ticks_to_irq("R7 after rearm", n);
        chk("R7 full period after rearm", n, 3);

        // R5 restart and stop
        do_cycle(1, A_ACK, 32'h8000_0000, 0, "R5 clr");
        do_cycle(1, A_CTRL, 32'h3000_0004, 0, "R5 start");
        for (int k = 0; k < 3; k++) do_cycle(0, A_CTRL, 0, 1, "R5 run");
        do_cycle(1, A_CTRL, 32'h3000_0004, 0, "R5 restart");
        ticks_to_irq("R5 after restart", n);
        chk("R5 restart period", n, 4);
        do_cycle(1, A_CTRL, 32'h2000_0004, 0, "R5 stop");
        chk("R5 flag kept on stop", bus_rdata, 32'hA000_0004);
        do_cycle(1, A_ACK, 32'h8000_0000, 0, "R5 clr2");
        for (int k = 0; k < 10; k++) do_cycle(0, A_CTRL, 0, 1, "R5 stopped");
        chk("R5 no fire stopped", {31'b0, irq_req}, 32'h0);
        // R7 rearm when stopped has no effect
        do_cycle(1, A_ACK, 32'h4000_0000, 1, "R7 stopped rearm");
        for (int k = 0; k < 6; k++) do_cycle(0, A_CTRL, 0, 1, "R7 stopped");
        chk("R7 no fire", {31'b0, irq_req}, 32'h0);

        // R9 zero reload
        do_cycle(1, A_CTRL, 32'h3000_0000, 0, "R9 zero");
        for (int k = 0; k < 20; k++) do_cycle(0, A_CTRL, 0, 1, "R9 ticks");
        chk("R9 no fire", {31'b0, irq_req}, 32'h0);

        // R11 no tick, no count
        do_cycle(1, A_CTRL, 32'h3000_0002, 0, "R11 start");
        for (int k = 0; k < 10; k++) do_cycle(0, A_CTRL, 0, 0, "R11 idle");
        chk("R11 no fire", {31'b0, irq_req}, 32'h0);
        ticks_to_irq("R11 resume", n);
        chk("R11 period intact", n, 2);

        // random traffic (R3 R4 R6 R7 R10 against model)
        for (int k = 0; k < 4000; k++) begin
            wr = ($urandom % 10) == 0;
            case ($urandom % 5)
                0, 1:    a = A_CTRL;
                2, 3:    a = A_ACK;
                default: a = A_OTH;
            endcase
            wd = $urandom;
            wd[27:0] = 28'($urandom % 6);
            do_cycle(wr, a, wd, 1'($urandom % 2), "R4 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule